// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block is the engine of one DMA channel. It walks a linked list of command structures held in memory. For each structure it does the following, in order:

- It reads a three-word header.
- It writes zero or more register words to a peripheral, starting at the peripheral's base register.
- It moves a programmed number of bytes between a memory buffer and the peripheral, one 32-bit beat per handshake.
- If asked, it waits for the peripheral to report end of command, which the peripheral signals by changing the level of a toggle line.

At completion it can decrement a software-owned semaphore and raise a sticky interrupt flag. It then follows the next-structure pointer, but only if the structure's chain flag is set.

Software gives the channel its first structure address through a small control port and releases work by adding to the semaphore. The channel starts a structure only when the semaphore is nonzero. A next pointer of zero is an ordinary address: only the chain flag decides whether the list goes on.

Header layout, as a byte offset from the structure address A:

| Offset | Content |
|---|---|
| A+0 | Next-structure address |
| A+4 | Control word |
| A+8 | Buffer address |
| A+12 onward | The register words to write |

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, mem_req, dev_req and pio_we are low, csr_sema reads 0 and csr_irq reads 0.
- R2: No header read is issued while the semaphore is zero or no structure is pending. When both conditions hold, the channel reads A, A+4 and A+8 in that order, and holds each memory request and its address stable until mem_ack.
- R3: Control bits 15:12 give N register words. The channel reads them from A+12 upward and writes them in order to pio_idx 0 to N-1 with the word read as pio_data.
- R4: With control bits 1:0 equal to 1, the channel reads ceil(B/4) words from consecutive buffer addresses and hands each, in order, to the device with dev_dir high. B is the byte count in control bits 31:16. When B is 0, no beat occurs.
- R5: With control bits 1:0 equal to 2, the channel takes ceil(B/4) words from the device with dev_dir low and writes them to consecutive buffer addresses.
- R6: With control bit 7 set, completion waits until end_tgl has changed level, on either a rising or a falling edge, since the structure started.
- R7: With control bit 6 set, completion lowers the semaphore by one. An increment in the same cycle nets with the decrement.
- R8: With control bit 3 set, completion sets csr_irq. The flag then stays set until a control write with csr_sel 1 and csr_wdata[0] high. A set in the same cycle as that clear wins.
- R9: With control bit 2 set, the next structure is fetched from the address in word A+0, even when that address is zero. With the bit clear, the channel goes idle and makes no further reads.
- R10: A control write with csr_sel 0 adds csr_wdata[7:0] to the semaphore, saturating at 255. A write with csr_sel 2 loads the pending structure address while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Control write strobe |
| csr_sel | input | 2 | 0 add to semaphore, 1 clear interrupt, 2 load structure address |
| csr_wdata | input | 32 | Control write data |
| csr_sema | output | 8 | Semaphore value |
| csr_irq | output | 1 | Sticky interrupt flag |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request done |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| pio_we | output | 1 | Peripheral register write strobe |
| pio_idx | output | 4 | Register index from base |
| pio_data | output | 32 | Register write data |
| dev_req | output | 1 | Data beat request, held until dev_ack |
| dev_dir | output | 1 | 1 to device, 0 from device |
| dev_wdata | output | 32 | Beat data to device |
| dev_ack | input | 1 | Beat done |
| dev_rdata | input | 32 | Beat data from device, valid with dev_ack |
| end_tgl | input | 1 | End-of-command toggle |

## Verification
Two actions can fall in the same clock edge: a software increment of the semaphore and the hardware decrement at completion of a structure that waits for end of command. The bench toggles end_tgl and, starting in that same cycle, issues an increment on each of ten consecutive cycles. Completion is only a few cycles behind the toggle, so it lands inside that window whatever the exact latency. The final semaphore is then compared with the start value plus ten minus one. A dropped or doubled update shows up as an off-by-one result.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int BC_W   = 16;
  localparam int BEAT_W = BC_W - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_PIO, S_MRD, S_DWR, S_DRD, S_MWR, S_WAIT, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0, XF_TO_DEV = 2'd1, XF_FROM_DEV = 2'd2, XF_RSVD = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic [BC_W-1:0] nbytes;
    logic [3:0]      npio;
    logic [3:0]      rsvd_a;
    logic            wait_end;
    logic            dec_sema;
    logic [1:0]      rsvd_b;
    logic            irq;
    logic            chain;
    logic [1:0]      kind;
  } ctl_word_t;

  function automatic logic [BEAT_W-1:0] beat_count(input logic [BC_W-1:0] nb);
    logic [BC_W:0] t;
    t = {1'b0, nb} + (BC_W+1)'(3);
    return t[BC_W:2];
  endfunction

  function automatic seq_state_e data_entry(input ctl_word_t c);
    if (c.nbytes == '0) return S_WAIT;
    case (xfer_kind_e'(c.kind))
      XF_TO_DEV:   return S_MRD;
      XF_FROM_DEV: return S_DRD;
      default:     return S_WAIT;
    endcase
  endfunction

endpackage

// File: rtl/dmac_end_watch.sv
module dmac_end_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic end_tgl,
  input  logic clr,
  output logic seen
);
  logic prev_q;
  logic seen_q;
  logic end_evt;

  assign end_evt = end_tgl ^ prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= end_tgl;
      if (end_evt)  seen_q <= 1'b1;
      else if (clr) seen_q <= 1'b0;
    end
  end

  assign seen = seen_q;
endmodule

// File: rtl/dmac_sema_irq.sv
module dmac_sema_irq #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] inc_amt,
  input  logic          dec_req,
  input  logic          irq_set,
  input  logic          irq_clr,
  output logic [SW-1:0] sema,
  output logic          irq
);
  logic [SW-1:0] sema_q;
  logic          irq_q;

  function automatic logic [SW-1:0] sema_step(input logic [SW-1:0] cur,
                                              input logic [SW-1:0] inc,
                                              input logic          dec);
    logic [SW:0] sum;
    sum = {1'b0, cur} + {1'b0, inc};
    if (sum[SW]) sum = {1'b0, {SW{1'b1}}};
    if (dec && (sum != '0)) sum = sum - (SW+1)'(1);
    return sum[SW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sema_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      sema_q <= sema_step(sema_q, inc_amt, dec_req);
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign sema = sema_q;
  assign irq  = irq_q;
endmodule

// File: rtl/dmac_seq_fsm.sv
module dmac_seq_fsm
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sema_nz,
  input  logic          head_we,
  input  logic [AW-1:0] head_addr,
  input  logic          end_seen,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          pio_we,
  output logic [3:0]    pio_idx,
  output logic [31:0]   pio_data,
  output logic          dev_req,
  output logic          dev_dir,
  output logic [31:0]   dev_wdata,
  input  logic          dev_ack,
  input  logic [31:0]   dev_rdata,
  output logic          cmd_start,
  output logic          cmd_done,
  output logic          have_cmd,
  output logic [3:0]    cur_npio,
  output logic          cur_wait,
  output logic          cur_dec,
  output logic          cur_irq,
  output logic          cur_chain
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] PIO_BASE = AW'(12);

  seq_state_e        state;
  ctl_word_t         ctl_q;
  logic              have_q;
  logic [AW-1:0]     cmd_addr, nxt_addr, beat_addr;
  logic [BEAT_W-1:0] beat_left;
  logic [1:0]        widx;
  logic [3:0]        pio_k;
  logic [31:0]       data_q;
  logic              pio_we_q;
  logic [3:0]        pio_idx_q;
  logic [31:0]       pio_data_q;
  logic              last_beat;
  logic              unused_rsvd;

  assign unused_rsvd = ^{ctl_q.rsvd_a, ctl_q.rsvd_b};
  assign last_beat   = (beat_left == BEAT_W'(1));
  assign cmd_start   = (state == S_IDLE) && !head_we && have_q && sema_nz;
  assign cmd_done    = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ctl_q      <= '0;
      have_q     <= 1'b0;
      cmd_addr   <= '0;
      nxt_addr   <= '0;
      beat_addr  <= '0;
      beat_left  <= '0;
      widx       <= '0;
      pio_k      <= '0;
      data_q     <= '0;
      pio_we_q   <= 1'b0;
      pio_idx_q  <= '0;
      pio_data_q <= '0;
    end else begin
      pio_we_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (head_we) begin
            cmd_addr <= head_addr;
            have_q   <= 1'b1;
          end else if (cmd_start) begin
            widx  <= '0;
            state <= S_HDR;
          end
        end
        S_HDR: if (mem_ack) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: nxt_addr <= mem_rdata[AW-1:0];
            2'd1: ctl_q    <= ctl_word_t'(mem_rdata);
            default: begin
              beat_addr <= mem_rdata[AW-1:0];
              beat_left <= beat_count(ctl_q.nbytes);
              pio_k     <= '0;
              state     <= (ctl_q.npio != 4'd0) ? S_PIO : data_entry(ctl_q);
            end
          endcase
        end
        S_PIO: if (mem_ack) begin
          pio_we_q   <= 1'b1;
          pio_idx_q  <= pio_k;
          pio_data_q <= mem_rdata;
          if (pio_k == ctl_q.npio - 4'd1) state <= data_entry(ctl_q);
          else                            pio_k <= pio_k + 4'd1;
        end
        S_MRD: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_DWR;
        end
        S_DWR: if (dev_ack) begin
          beat_left <= beat_left - BEAT_W'(1);
          beat_addr <= beat_addr + STEP;
          state     <= last_beat ? S_WAIT : S_MRD;
        end
        S_DRD: if (dev_ack) begin
          data_q <= dev_rdata;
          state  <= S_MWR;
        end
        S_MWR: if (mem_ack) begin
          beat_left <= beat_left - BEAT_W'(1);
          beat_addr <= beat_addr + STEP;
          state     <= last_beat ? S_WAIT : S_DRD;
        end
        S_WAIT: if (!ctl_q.wait_end || end_seen) state <= S_DONE;
        S_DONE: begin
          have_q <= ctl_q.chain;
          if (ctl_q.chain) cmd_addr <= nxt_addr;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = beat_addr;
    case (state)
      S_HDR: begin
        mem_req  = 1'b1;
        mem_addr = cmd_addr + AW'({widx, 2'b00});
      end
      S_PIO: begin
        mem_req  = 1'b1;
        mem_addr = cmd_addr + PIO_BASE + AW'({pio_k, 2'b00});
      end
      S_MRD: mem_req = 1'b1;
      S_MWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_wdata = data_q;
  assign dev_req   = (state == S_DWR) || (state == S_DRD);
  assign dev_dir   = (state == S_DWR);
  assign dev_wdata = data_q;
  assign pio_we    = pio_we_q;
  assign pio_idx   = pio_idx_q;
  assign pio_data  = pio_data_q;
  assign have_cmd  = have_q;
  assign cur_npio  = ctl_q.npio;
  assign cur_wait  = ctl_q.wait_end;
  assign cur_dec   = ctl_q.dec_sema;
  assign cur_irq   = ctl_q.irq;
  assign cur_chain = ctl_q.chain;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [1:0]    csr_sel,
  input  logic [31:0]   csr_wdata,
  output logic [SW-1:0] csr_sema,
  output logic          csr_irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          pio_we,
  output logic [3:0]    pio_idx,
  output logic [31:0]   pio_data,
  output logic          dev_req,
  output logic          dev_dir,
  output logic [31:0]   dev_wdata,
  input  logic          dev_ack,
  input  logic [31:0]   dev_rdata,
  input  logic          end_tgl
);
  localparam logic [1:0] SEL_INC  = 2'd0;
  localparam logic [1:0] SEL_CLR  = 2'd1;
  localparam logic [1:0] SEL_HEAD = 2'd2;

  logic          cmd_start, cmd_done, have_cmd, end_seen;
  logic [3:0]    cur_npio;
  logic          cur_wait, cur_dec, cur_irq, cur_chain;
  logic [SW-1:0] inc_amt;
  logic          irq_clr, head_we, dec_req, irq_set;
  logic [SW-1:0] sema;
  logic          irq;

  assign inc_amt = (csr_we && csr_sel == SEL_INC) ? csr_wdata[SW-1:0] : '0;
  assign irq_clr = csr_we && (csr_sel == SEL_CLR) && csr_wdata[0];
  assign head_we = csr_we && (csr_sel == SEL_HEAD);
  assign dec_req = cmd_done && cur_dec;
  assign irq_set = cmd_done && cur_irq;

  dmac_seq_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sema_nz(sema != '0),
    .head_we(head_we), .head_addr(csr_wdata[AW-1:0]), .end_seen(end_seen),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
    .dev_req(dev_req), .dev_dir(dev_dir), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata),
    .cmd_start(cmd_start), .cmd_done(cmd_done), .have_cmd(have_cmd),
    .cur_npio(cur_npio), .cur_wait(cur_wait), .cur_dec(cur_dec),
    .cur_irq(cur_irq), .cur_chain(cur_chain)
  );

  dmac_end_watch u_end (
    .clk(clk), .rst_n(rst_n), .end_tgl(end_tgl), .clr(cmd_start), .seen(end_seen)
  );

  dmac_sema_irq #(.SW(SW)) u_sema (
    .clk(clk), .rst_n(rst_n), .inc_amt(inc_amt), .dec_req(dec_req),
    .irq_set(irq_set), .irq_clr(irq_clr), .sema(sema), .irq(irq)
  );

  assign csr_sema = sema;
  assign csr_irq  = irq;
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          cmd_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          pio_we,
  input logic [3:0]    pio_idx,
  input logic [3:0]    cur_npio,
  input logic          cur_wait,
  input logic          cur_dec,
  input logic          cur_irq,
  input logic          cur_chain,
  input logic          end_seen,
  input logic [SW-1:0] sema,
  input logic [SW-1:0] inc_amt,
  input logic          irq,
  input logic          irq_clr,
  input logic          have_cmd
);
  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (mem_req && !mem_we)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
  AST_PIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pio_we |-> (pio_idx < cur_npio)); // R3
  AST_WAIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cur_wait) |-> end_seen); // R6
  AST_SEMA_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cur_dec && inc_amt == '0 && sema != '0) |=> (sema == $past(sema) - SW'(1))); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cur_irq) |=> irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R8
  AST_CHAIN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cur_chain) |=> !have_cmd); // R9
endmodule

bind dma_chain_seq dma_chain_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_done(cmd_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .pio_we(pio_we), .pio_idx(pio_idx), .cur_npio(cur_npio), .cur_wait(cur_wait),
  .cur_dec(cur_dec), .cur_irq(cur_irq), .cur_chain(cur_chain),
  .end_seen(end_seen), .sema(sema), .inc_amt(inc_amt), .irq(irq),
  .irq_clr(irq_clr), .have_cmd(have_cmd)
);

// File: tb/dma_chain_seq_tb.sv
module dma_chain_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [7:0]  csr_sema;
  logic        csr_irq;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        pio_we;
  logic [3:0]  pio_idx;
  logic [31:0] pio_data;
  logic        dev_req, dev_dir, dev_ack;
  logic [31:0] dev_wdata, dev_rdata;
  logic        end_tgl = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;
  logic [31:0] dev_seq;

  logic [31:0] rd_log [0:255];
  logic [31:0] pio_log [0:255];
  logic [3:0]  pidx_log [0:255];
  logic [31:0] out_log [0:255];
  logic [31:0] in_log [0:255];
  int rd_n = 0, pio_n = 0, out_n = 0, in_n = 0;

  always #2.5 clk = ~clk;

  dma_chain_seq u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_sema(csr_sema), .csr_irq(csr_irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
    .dev_req(dev_req), .dev_dir(dev_dir), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .end_tgl(end_tgl)
  );

  // memory and device models
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      dev_ack   <= 1'b0;
      mem_rdata <= '0;
      dev_rdata <= '0;
      dev_seq   <= 32'hD00D_0000;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[9:2]];
      end
      dev_ack <= dev_req && !dev_ack;
      if (dev_req && !dev_ack) begin
        dev_rdata <= dev_seq;
        dev_seq   <= dev_seq + 32'd1;
      end
    end
    if (tb_we) mem[tb_idx] <= tb_dat;
  end

  // event logs
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack && !mem_we) begin rd_log[rd_n] <= mem_addr; rd_n <= rd_n + 1; end
      if (pio_we) begin pio_log[pio_n] <= pio_data; pidx_log[pio_n] <= pio_idx; pio_n <= pio_n + 1; end
      if (dev_req && dev_ack) begin
        if (dev_dir) begin out_log[out_n] <= dev_wdata; out_n <= out_n + 1; end
        else         begin in_log[in_n] <= dev_rdata; in_n <= in_n + 1; end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mem_put(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = addr[9:2]; tb_dat = data;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic csr_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!csr_irq && n < 3000) begin @(negedge clk); n++; end
    chk(req, "irq raised at completion", {31'd0, csr_irq}, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1", "dev_req", {31'd0, dev_req}, 32'd0);
    chk("R1", "pio_we", {31'd0, pio_we}, 32'd0);
    chk("R1", "sema", {24'd0, csr_sema}, 32'd0);
    chk("R1", "irq", {31'd0, csr_irq}, 32'd0);
  endtask

  // to-device transfer with PIO words, gated start
  task automatic t_to_dev();
    int r0, p0, o0;
    logic [31:0] ea [8];
    ea = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h110, 32'h200, 32'h204, 32'h208};
    mem_put(32'h100, 32'h0000_0300);
    mem_put(32'h104, 32'h000A_2049);
    mem_put(32'h108, 32'h0000_0200);
    mem_put(32'h10C, 32'hA1A1_0001);
    mem_put(32'h110, 32'hA1A1_0002);
    for (int i = 0; i < 3; i++) mem_put(32'h200 + 32'(4*i), 32'hB0B0_0000 + 32'(i));
    r0 = rd_n; p0 = pio_n; o0 = out_n;
    csr_wr(2'd2, 32'h100);
    repeat (20) @(negedge clk);
    chk("R2", "no read while semaphore zero", 32'(rd_n - r0), 32'd0);
    csr_wr(2'd0, 32'd1);
    wait_irq("R8");
    chk("R2", "read count", 32'(rd_n - r0), 32'd8);
    for (int i = 0; i < 8; i++) chk("R2", "read address order", rd_log[r0+i], ea[i]);
    chk("R3", "pio count", 32'(pio_n - p0), 32'd2);
    chk("R3", "pio idx0", {28'd0, pidx_log[p0]}, 32'd0);
    chk("R3", "pio data0", pio_log[p0], 32'hA1A1_0001);
    chk("R3", "pio idx1", {28'd0, pidx_log[p0+1]}, 32'd1);
    chk("R3", "pio data1", pio_log[p0+1], 32'hA1A1_0002);
    chk("R4", "beats for 10 bytes", 32'(out_n - o0), 32'd3);
    for (int i = 0; i < 3; i++) chk("R4", "beat data", out_log[o0+i], 32'hB0B0_0000 + 32'(i));
    chk("R7", "semaphore decremented", {24'd0, csr_sema}, 32'd0);
    repeat (30) @(negedge clk);
    chk("R9", "no read after unchained end", 32'(rd_n - r0), 32'd8);
    chk("R8", "irq sticky", {31'd0, csr_irq}, 32'd1);
    csr_wr(2'd1, 32'd1);
    chk("R8", "irq cleared", {31'd0, csr_irq}, 32'd0);
  endtask

  // from-device transfer, chain to a structure at address zero
  task automatic t_from_dev_chain();
    int r0, p0, o0, i0;
    logic [31:0] ea [7];
    ea = '{32'h140, 32'h144, 32'h148, 32'h000, 32'h004, 32'h008, 32'h00C};
    mem_put(32'h140, 32'h0000_0000);
    mem_put(32'h144, 32'h0008_0046);
    mem_put(32'h148, 32'h0000_0280);
    mem_put(32'h000, 32'h0000_03C0);
    mem_put(32'h004, 32'h0000_1049);
    mem_put(32'h008, 32'h0000_02C0);
    mem_put(32'h00C, 32'hC0C0_0009);
    r0 = rd_n; p0 = pio_n; o0 = out_n; i0 = in_n;
    csr_wr(2'd2, 32'h140);
    csr_wr(2'd0, 32'd2);
    wait_irq("R9");
    chk("R9", "reads through zero pointer", 32'(rd_n - r0), 32'd7);
    for (int i = 0; i < 7; i++) chk("R9", "read address order", rd_log[r0+i], ea[i]);
    chk("R5", "beats from device", 32'(in_n - i0), 32'd2);
    chk("R5", "buffer word 0", mem[8'hA0], in_log[i0]);
    chk("R5", "buffer word 1", mem[8'hA1], in_log[i0+1]);
    chk("R4", "zero byte count no beat", 32'(out_n - o0), 32'd0);
    chk("R3", "single pio", 32'(pio_n - p0), 32'd1);
    chk("R3", "single pio data", pio_log[p0], 32'hC0C0_0009);
    chk("R7", "two decrements", {24'd0, csr_sema}, 32'd0);
    csr_wr(2'd1, 32'd1);
  endtask

  // end-of-command wait, both edges, with coincident increment
  task automatic t_wait_end();
    mem_put(32'h180, 32'h0000_0000);
    mem_put(32'h184, 32'h0000_00C8);
    mem_put(32'h188, 32'h0000_0000);
    csr_wr(2'd2, 32'h180);
    csr_wr(2'd0, 32'd1);
    repeat (40) @(negedge clk);
    chk("R6", "held without toggle irq", {31'd0, csr_irq}, 32'd0);
    chk("R6", "held without toggle sema", {24'd0, csr_sema}, 32'd1);
    @(negedge clk);
    end_tgl = 1'b1;
    csr_we = 1'b1; csr_sel = 2'd0; csr_wdata = 32'd1;
    repeat (10) @(negedge clk);
    csr_we = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6", "rising edge completes", {31'd0, csr_irq}, 32'd1);
    chk("R7", "coincident inc and dec net", {24'd0, csr_sema}, 32'd10);
    csr_wr(2'd1, 32'd1);
    csr_wr(2'd2, 32'h180);
    repeat (20) @(negedge clk);
    chk("R6", "second wait held", {31'd0, csr_irq}, 32'd0);
    end_tgl = 1'b0;
    wait_irq("R6");
    chk("R7", "falling edge decrement", {24'd0, csr_sema}, 32'd9);
  endtask

  task automatic t_saturate();
    int r0;
    r0 = rd_n;
    csr_wr(2'd0, 32'd200);
    chk("R10", "add", {24'd0, csr_sema}, 32'd209);
    csr_wr(2'd0, 32'd100);
    chk("R10", "saturate", {24'd0, csr_sema}, 32'd255);
    repeat (10) @(negedge clk);
    chk("R9", "idle without pending structure", 32'(rd_n - r0), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_to_dev();
    t_from_dev_chain();
    t_wait_end();
    t_saturate();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule